// File: doc/BRIEF.md
# Downstream Channel Connection Controller

This block owns the channel-select state of a two-wire bus switch that links one upstream bus to any mix of several downstream buses. The host writes a connect mask through a write strobe; for every channel named in the mask the block decides whether the switch for that channel may close. A channel is closed only when both of its downstream lines, SDA and SCL, are seen high after synchronization. If a line is low, the request for that channel is refused, the channel stays open and a sticky failed-connection flag is raised. A configuration bit written by the host lets requests go through whatever the downstream level.

The synchronized downstream levels are brought out so that the host can look at a bus before it asks for that bus. A ready output shows that at least one channel is linked. The stuck-low timer outside the block can open every switch at once. Pulling the enable input low puts everything back to its reset state, and the block then ignores the host.

Top module: `chan_link_ctrl`

## Requirements
- R1: After reset `sw_en` is 0, `ready` is 0, `conn_fail` is 0 and the override bit is clear.
- R2: `bus_hi[i]` is 1 exactly when both `ds_sda[i]` and `ds_scl[i]` are 1, and it follows a change of either line after two clock edges.
- R3: A clock edge with `req_we` high replaces the whole connection state. `sw_en[i]` is 1 on the next cycle for every set bit `req_data[i]` that is accepted, and every channel whose `req_data` bit is 0 is opened.
- R4: With the override bit clear, a requested channel whose `bus_hi` is 0 is left open and `conn_fail` becomes 1 on the next cycle.
- R5: Each channel is judged on its own. In a mixed request the high channels close and only the low ones are refused.
- R6: An edge with `cfg_we` high loads `cfg_force` into the override bit. While that bit is 1, every requested channel closes and `conn_fail` is not set.
- R7: `ready` is 1 whenever at least one bit of `sw_en` is 1, and 0 otherwise.
- R8: An edge with `stuck_timeout` high opens all channels. A request on the same edge is dropped without connecting anything and without raising a fault, and the fault flag keeps its value.
- R9: `conn_fail` stays 1 until an edge with `fail_clr` high. If a refusal and `fail_clr` fall on the same edge, the flag ends up 1.
- R10: While `enable` is low, every edge clears `sw_en`, `conn_fail`, the override bit and the synchronizers (`bus_hi` reads 0), and it ignores `req_we`, `cfg_we` and `fail_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low holds the block at its defaults |
| req_we | input | 1 | Write strobe for the connect mask |
| req_data | input | NUM_CH | Connect mask, bit i selects channel i |
| cfg_we | input | 1 | Write strobe for the override bit |
| cfg_force | input | 1 | New value of the override bit |
| fail_clr | input | 1 | Clears the failed-connection flag |
| stuck_timeout | input | 1 | Stuck-low timer expiry; opens every channel |
| ds_sda | input | NUM_CH | Sampled downstream SDA levels |
| ds_scl | input | NUM_CH | Sampled downstream SCL levels |
| bus_hi | output | NUM_CH | Synchronized per-channel idle-high level |
| sw_en | output | NUM_CH | Per-channel switch enable |
| ready | output | 1 | At least one channel is connected |
| conn_fail | output | 1 | Sticky failed-connection flag |

## Verification
The bench holds SCL high and pulls only SDA low, or the reverse, to catch a check that looks at only one line; such a design would close a channel whose bus is still busy. Mixed masks catch a design that refuses the whole request when any one channel is low, or that fails to open channels missing from the mask. A request that lands on the same edge as a timeout, and a clear that lands on the same edge as a refusal, show whether the priorities are right; a wrong design would be left linked or would lose the fault. A write made while the block is disabled, followed by a read-back once it is enabled again, shows that the override bit and the connection state were not changed.

// File: rtl/chan_link_pkg.sv
package chan_link_pkg;

   typedef enum logic [1:0] {
      GATE_OPEN   = 2'd0,
      GATE_CLOSE  = 2'd1,
      GATE_REFUSE = 2'd2
   } gate_dec_t;

   // Decision for one channel on a connect-mask write.
   function automatic gate_dec_t gate_decide(input logic want,
                                             input logic idle_hi,
                                             input logic force_en);
      gate_dec_t d;
      if (!want)
         d = GATE_OPEN;
      else if (idle_hi || force_en)
         d = GATE_CLOSE;
      else
         d = GATE_REFUSE;
      return d;
   endfunction

endpackage

// File: rtl/chan_sync.sv
module chan_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("chan_sync: W must be at least 1");
   end
   if (STAGES < 0) begin : g_bad_stages
      $error("chan_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg <= '0;
         end else if (clr) begin
            stg <= '0;
         end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
               stg[s] <= stg[s-1];
            end
         end
      end
      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/chan_gate_bank.sv
module chan_gate_bank
   import chan_link_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              kill,
   input  logic              wr,
   input  logic [NUM_CH-1:0] want,
   input  logic [NUM_CH-1:0] idle_hi,
   input  logic              force_en,
   output logic [NUM_CH-1:0] sw_en,
   output logic [NUM_CH-1:0] refuse
);

   if (NUM_CH < 1) begin : g_bad_n
      $error("chan_gate_bank: NUM_CH must be at least 1");
   end

   logic accept_wr;
   assign accept_wr = enable && !kill && wr;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      gate_dec_t dec;
      logic      sw_q;

      assign dec = gate_decide(want[i], idle_hi[i], force_en);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sw_q <= 1'b0;
         end else if (!enable || kill) begin
            sw_q <= 1'b0;
         end else if (wr) begin
            sw_q <= (dec == GATE_CLOSE);
         end
      end

      assign sw_en[i]  = sw_q;
      assign refuse[i] = accept_wr && (dec == GATE_REFUSE);
   end

endmodule

// File: rtl/fail_latch.sv
module fail_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (!enable) begin
         q <= 1'b0;
      end else if (set) begin
         q <= 1'b1;
      end else if (clr) begin
         q <= 1'b0;
      end
   end

endmodule

// File: rtl/chan_link_ctrl.sv
module chan_link_ctrl #(
   parameter int NUM_CH      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              req_we,
   input  logic [NUM_CH-1:0] req_data,
   input  logic              cfg_we,
   input  logic              cfg_force,
   input  logic              fail_clr,
   input  logic              stuck_timeout,
   input  logic [NUM_CH-1:0] ds_sda,
   input  logic [NUM_CH-1:0] ds_scl,
   output logic [NUM_CH-1:0] bus_hi,
   output logic [NUM_CH-1:0] sw_en,
   output logic              ready,
   output logic              conn_fail
);

   localparam int SYNC_W = 2 * NUM_CH;

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_n
      $error("chan_link_ctrl: NUM_CH out of range 1..32");
   end
   if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("chan_link_ctrl: SYNC_STAGES out of range 0..4");
   end

   logic [SYNC_W-1:0] line_raw;
   logic [SYNC_W-1:0] line_syn;
   logic [NUM_CH-1:0] refuse;
   logic              force_q;

   assign line_raw = {ds_scl, ds_sda};

   chan_sync #(
      .W      (SYNC_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!enable),
      .d     (line_raw),
      .q     (line_syn)
   );

   // The bus counts as idle only when both lines read high.
   assign bus_hi = line_syn[NUM_CH-1:0] & line_syn[SYNC_W-1:NUM_CH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         force_q <= 1'b0;
      end else if (!enable) begin
         force_q <= 1'b0;
      end else if (cfg_we) begin
         force_q <= cfg_force;
      end
   end

   chan_gate_bank #(
      .NUM_CH (NUM_CH)
   ) u_gates (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .kill     (stuck_timeout),
      .wr       (req_we),
      .want     (req_data),
      .idle_hi  (bus_hi),
      .force_en (force_q),
      .sw_en    (sw_en),
      .refuse   (refuse)
   );

   fail_latch u_fail (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (enable),
      .set    (|refuse),
      .clr    (fail_clr),
      .q      (conn_fail)
   );

   assign ready = |sw_en;

endmodule

// File: rtl/chan_link_chk.sv
module chan_link_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              req_we,
   input logic [NUM_CH-1:0] req_data,
   input logic              fail_clr,
   input logic              stuck_timeout,
   input logic [NUM_CH-1:0] bus_hi,
   input logic [NUM_CH-1:0] sw_en,
   input logic              ready,
   input logic              conn_fail,
   input logic              force_q
);

   // R4
   low_req_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && req_we && !stuck_timeout && !force_q && ((req_data & ~bus_hi) != '0))
      |=> conn_fail);

   // R5
   only_high_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && req_we && !stuck_timeout && !force_q)
      |=> ((sw_en & ~$past(bus_hi)) == '0));

   // R3
   close_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sw_en & ~$past(sw_en)) != '0) |-> $past(req_we));

   // R7
   ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> ($past(req_we) && $past(enable)));

   // R8
   timeout_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stuck_timeout |=> (sw_en == '0));

   // R9
   fail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(conn_fail) |-> ($past(fail_clr) || !$past(enable)));

   // R10
   disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (sw_en == '0 && !conn_fail && !force_q));

endmodule

bind chan_link_ctrl chan_link_chk #(
   .NUM_CH (NUM_CH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .req_we        (req_we),
   .req_data      (req_data),
   .fail_clr      (fail_clr),
   .stuck_timeout (stuck_timeout),
   .bus_hi        (bus_hi),
   .sw_en         (sw_en),
   .ready         (ready),
   .conn_fail     (conn_fail),
   .force_q       (force_q)
);

// File: tb/sim_chan_link_ctrl.sv
module sim_chan_link_ctrl;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic         req_we = 1'b0;
   logic [N-1:0] req_data = '0;
   logic         cfg_we = 1'b0;
   logic         cfg_force = 1'b0;
   logic         fail_clr = 1'b0;
   logic         stuck_timeout = 1'b0;
   logic [N-1:0] ds_sda = '1;
   logic [N-1:0] ds_scl = '1;
   logic [N-1:0] bus_hi;
   logic [N-1:0] sw_en;
   logic         ready;
   logic         conn_fail;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [N-1:0] m_sw;
   logic         m_fail;
   logic         m_force;

   always #4 clk = ~clk;

   chan_link_ctrl #(.NUM_CH(N), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable), .req_we(req_we),
      .req_data(req_data), .cfg_we(cfg_we), .cfg_force(cfg_force),
      .fail_clr(fail_clr), .stuck_timeout(stuck_timeout), .ds_sda(ds_sda),
      .ds_scl(ds_scl), .bus_hi(bus_hi), .sw_en(sw_en), .ready(ready),
      .conn_fail(conn_fail)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] exp_hi();
      return ds_sda & ds_scl;
   endfunction

   // Model of a connect-mask write
   function automatic void model_req(input logic [N-1:0] d);
      logic [N-1:0] hi = exp_hi();
      for (int i = 0; i < N; i++) begin
         if (!d[i]) m_sw[i] = 1'b0;
         else if (hi[i] || m_force) m_sw[i] = 1'b1;
         else begin m_sw[i] = 1'b0; m_fail = 1'b1; end
      end
   endfunction

   task automatic check_outs(input string tag);
      check({tag, " sw_en"}, 32'(sw_en), 32'(m_sw));
      check({tag, " conn_fail"}, 32'(conn_fail), 32'(m_fail));
      check("R7 ready", 32'(ready), 32'(|m_sw));
   endtask

   task automatic set_lines(input logic [N-1:0] sda, input logic [N-1:0] scl);
      @(negedge clk);
      ds_sda = sda; ds_scl = scl;
      repeat (3) @(negedge clk);
      check("R2 bus_hi", 32'(bus_hi), 32'(sda & scl));
   endtask

   task automatic do_req(input logic [N-1:0] d, input logic clr_too, input logic tmo);
      @(negedge clk);
      req_data = d; req_we = 1'b1; fail_clr = clr_too; stuck_timeout = tmo;
      if (tmo) m_sw = '0;
      else begin
         if (clr_too) m_fail = 1'b0;
         model_req(d);
      end
      @(negedge clk);
      req_we = 1'b0; fail_clr = 1'b0; stuck_timeout = 1'b0;
   endtask

   task automatic do_cfg(input logic f);
      @(negedge clk);
      cfg_we = 1'b1; cfg_force = f;
      m_force = f;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk);
      fail_clr = 1'b1; m_fail = 1'b0;
      @(negedge clk);
      fail_clr = 1'b0;
      check("R9 clear", 32'(conn_fail), 32'(0));
   endtask

   task automatic do_timeout();
      @(negedge clk);
      stuck_timeout = 1'b1; m_sw = '0;
      @(negedge clk);
      stuck_timeout = 1'b0;
      check_outs("R8 timeout");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'h5eed_1234;
      void'($urandom(seed));
      m_sw = '0; m_fail = 1'b0; m_force = 1'b0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1; enable = 1'b1;
      @(negedge clk);
      check_outs("R1 reset");
      check("R1 bus_hi", 32'(bus_hi), 32'(0));

      // R2 latency: visible after the second edge only
      repeat (3) @(negedge clk);
      check("R2 idle", 32'(bus_hi), 32'hF);
      ds_sda = 4'b1110;
      @(negedge clk);
      check("R2 one edge", 32'(bus_hi), 32'hF);
      @(negedge clk);
      check("R2 two edges", 32'(bus_hi), 32'hE);

      // R1 override clear after reset: low channel refused
      set_lines(4'b1110, 4'b1111);
      do_req(4'b0001, 1'b0, 1'b0);
      check_outs("R4 sda low");
      do_clr();
      // SCL low only
      set_lines(4'b1111, 4'b1011);
      do_req(4'b0100, 1'b0, 1'b0);
      check_outs("R4 scl low");
      // R5 mixed request
      set_lines(4'b0111, 4'b1101);
      do_req(4'b1111, 1'b0, 1'b0);
      check_outs("R5 mixed");
      check("R5 sw_en", 32'(sw_en), 32'h5);
      // R9 set wins over clear
      do_req(4'b0010, 1'b1, 1'b0);
      check_outs("R9 set wins");
      do_clr();
      // R3 replace: connect 0 then 2
      set_lines(4'b1111, 4'b1111);
      do_req(4'b0001, 1'b0, 1'b0);
      check_outs("R3 first");
      do_req(4'b0100, 1'b0, 1'b0);
      check_outs("R3 replace");
      do_req(4'b0000, 1'b0, 1'b0);
      check_outs("R3 none");
      // R6 override
      set_lines(4'b0000, 4'b1111);
      do_cfg(1'b1);
      do_req(4'b1011, 1'b0, 1'b0);
      check_outs("R6 force");
      // R8 timeout alone, then request on a timeout edge
      do_timeout();
      do_cfg(1'b0);
      do_req(4'b1111, 1'b0, 1'b1);
      check_outs("R8 same edge");
      // R10 disable clears and ignores writes
      set_lines(4'b1111, 4'b1111);
      do_req(4'b0011, 1'b0, 1'b0);
      set_lines(4'b1110, 4'b1111);
      do_req(4'b0101, 1'b0, 1'b0);
      check_outs("R10 prep");
      @(negedge clk);
      enable = 1'b0;
      m_sw = '0; m_fail = 1'b0; m_force = 1'b0;
      @(negedge clk);
      check_outs("R10 disabled");
      check("R10 bus_hi", 32'(bus_hi), 32'(0));
      req_we = 1'b1; req_data = 4'b1110; cfg_we = 1'b1; cfg_force = 1'b1;
      @(negedge clk);
      req_we = 1'b0; cfg_we = 1'b0;
      check_outs("R10 ignored write");
      enable = 1'b1;
      repeat (3) @(negedge clk);
      check_outs("R10 reenabled");
      do_req(4'b0001, 1'b0, 1'b0);
      check_outs("R10 override stayed clear");
      do_clr();

      // Constrained random
      for (int it = 0; it < 300; it++) begin
         logic [N-1:0] sda = $urandom() | $urandom();
         logic [N-1:0] scl = $urandom() | $urandom();
         set_lines(sda, scl);
         if ($urandom_range(3) == 0) do_cfg(1'($urandom_range(1)));
         if ($urandom_range(3) == 0) do_clr();
         if ($urandom_range(7) == 0) do_timeout();
         do_req(N'($urandom()), 1'b0, ($urandom_range(15) == 0));
         check_outs(m_force ? "R6 random" : "R5 random");
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule